// File: doc/BRIEF.md
# Data-Dependent Vector Early-Exit Sequencer

This block walks a vector operation through its element indices in strict ascending order, starting at 0. For each element, the arithmetic datapath returns a 4-bit condition field derived from that element's result. The sequencer tests one bit of that field against an invert flag and decides three things:

- whether the element's result may reach the register file;
- whether its condition field is stored;
- whether the loop has to stop.

When a test fails, the sequencer cancels every later element. It then reports a shortened vector length, which either leaves out or includes the failing element. The shortened length may be zero.

A run begins with a one-cycle `start` pulse. That pulse captures the length, the mode controls and the predicate mask. After that, each cycle with `cr_valid` high consumes the condition field of the element shown on `elem_idx`. The write enables are combinational in the same cycle. Once the last element has been consumed, or a test has failed, a one-cycle `done` pulse and the committed length appear on the following clock edge.

Top module: `vec_ffirst_seq`

## Requirements
- R1: A `start` while idle captures `vl_in`, `rc`, `rc1`, `vli`, `inv`, `bit_sel` and `pred_mask`. With `vl_in` = 0, `done` rises on the next edge with `vl_out` = 0 and no element is processed.
- R2: Elements are consumed one per cycle with `cr_valid` high, in order 0, 1, 2, and so on. `elem_idx` shows the current element. Cycles with `cr_valid` low cause no writes and do not advance the index.
- R3: Condition field bit positions are: bit 3 = lt, bit 2 = gt, bit 1 = eq, bit 0 = so. With `rc`=1 the tested bit is chosen by `bit_sel` (0=lt, 1=gt, 2=eq, 3=so). With `rc`=0 the eq bit is tested. The test passes when the tested bit differs from `inv`.
- R4: On a failed test with inclusive mode off, the failing element's `reg_we` stays low and `vl_out` equals the failing index.
- R5: On a failed test with `vli`=1 and `rc`=0, the failing element's `reg_we` is high and `vl_out` equals the failing index plus one.
- R6: A failed test on element 0 with inclusive mode off commits `vl_out` = 0.
- R7: With `rc`=1, `vli` has no effect, and `cr_we` is high for every tested element, including the failing one.
- R8: With `rc1`=1, `reg_we` is never raised and `cr_we` is high for every tested element. The eq bit is tested.
- R9: If no tested element fails, `vl_out` equals the captured length, and `vl_out` never exceeds it.
- R10: An element whose predicate bit is 0 raises neither enable and cannot end the loop, but it still advances the index.
- R11: `done` is a one-cycle pulse on the edge after the final or failing element. `busy` is low from then on, and no enable rises while idle.
- R12: A `start` while busy is ignored and does not change the committed length.
- R13: With `rc`=0 and `rc1`=0, `cr_we` stays low and `reg_we` follows the test.

Parameter `MAXVL` (default 64) bounds `vl_in`. `vl_in` must not exceed `MAXVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| vl_in | input | $clog2(MAXVL+1) | Vector length for the run |
| rc | input | 1 | Condition-field-record mode; enables `bit_sel` test |
| rc1 | input | 1 | Compare-only mode: store condition field, discard result |
| vli | input | 1 | Inclusive truncation (only with `rc`=0) |
| inv | input | 1 | Invert flag for the bit test |
| bit_sel | input | 2 | Tested bit when `rc`=1 |
| pred_mask | input | MAXVL | Per-element predicate, bit i for element i |
| cr_valid | input | 1 | Condition field for current element is present |
| cr_in | input | 4 | Condition field {lt, gt, eq, so} |
| busy | output | 1 | Run in progress |
| elem_idx | output | $clog2(MAXVL) | Current element index |
| reg_we | output | 1 | Commit current element result |
| cr_we | output | 1 | Store current element condition field |
| done | output | 1 | One-cycle end-of-run pulse |
| vl_out | output | $clog2(MAXVL+1) | Committed vector length |

## Verification
A corrupted index register shows up immediately as a skipped or repeated `elem_idx` value in the next consuming cycle. It also shows up as enables that obey the wrong predicate bit. A latched mode bit that is wrong shows within the first unmasked element, as a wrong `reg_we` or `cr_we` in that same cycle. A wrong termination decision becomes visible one edge after the deciding element. It appears as a missing or early `done`, a `vl_out` off by one, or a `busy` that stays high and then lets enables fire for elements beyond the cut.

// File: rtl/vec_ffirst_seq.sv
module vec_ffirst_seq #(
  parameter int MAXVL = 64,
  localparam int IW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VW-1:0]    vl_in,
  input  logic             rc,
  input  logic             rc1,
  input  logic             vli,
  input  logic             inv,
  input  logic [1:0]       bit_sel,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             cr_valid,
  input  logic [3:0]       cr_in,
  output logic             busy,
  output logic [IW-1:0]    elem_idx,
  output logic             reg_we,
  output logic             cr_we,
  output logic             done,
  output logic [VW-1:0]    vl_out
);

  logic             busy_q, done_q;
  logic [IW-1:0]    idx_q;
  logic [VW-1:0]    vl_q, vlo_q;
  logic             rc_q, rc1_q, vli_q, inv_q;
  logic [1:0]       sel_q;
  logic [MAXVL-1:0] mask_q;

  logic          step, live, tbit, pass, incl, fail;
  logic [VW-1:0] nxt;

  assign step = busy_q & cr_valid;
  assign live = mask_q[idx_q];
  assign tbit = rc_q ? cr_in[2'd3 - sel_q] : cr_in[1];
  assign pass = tbit ^ inv_q;
  assign incl = vli_q & ~rc_q;
  assign fail = step & live & ~pass;
  assign nxt  = VW'(idx_q) + VW'(1);

  assign reg_we   = step & live & ~rc1_q & (pass | incl);
  assign cr_we    = step & live & (rc_q | rc1_q);
  assign busy     = busy_q;
  assign elem_idx = idx_q;
  assign done     = done_q;
  assign vl_out   = vlo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
      vlo_q  <= '0;
      rc_q   <= 1'b0;
      rc1_q  <= 1'b0;
      vli_q  <= 1'b0;
      inv_q  <= 1'b0;
      sel_q  <= '0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        vl_q   <= vl_in;
        rc_q   <= rc;
        rc1_q  <= rc1;
        vli_q  <= vli;
        inv_q  <= inv;
        sel_q  <= bit_sel;
        mask_q <= pred_mask;
        idx_q  <= '0;
        if (vl_in == '0) begin
          done_q <= 1'b1;
          vlo_q  <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (step) begin
        if (fail) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          vlo_q  <= incl ? nxt : VW'(idx_q);
        end else if (nxt == vl_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          vlo_q  <= vl_q;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

endmodule

module vec_ffirst_seq_chk #(
  parameter int MAXVL = 64,
  localparam int IW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cr_valid,
  input logic          busy,
  input logic [IW-1:0] elem_idx,
  input logic          reg_we,
  input logic          cr_we,
  input logic          done,
  input logic [VW-1:0] vl_out,
  input logic [VW-1:0] vl_lat,
  input logic          rc1_lat,
  input logic          live
);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_we && !cr_we));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_end_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_cmp_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rc1_lat) |-> !reg_we);

  assert_masked_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !live) |-> (!reg_we && !cr_we));

  assert_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cr_valid) |=> (!busy || elem_idx == IW'($past(elem_idx) + 1'b1)));

  assert_hold_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cr_valid) |=> $stable(elem_idx));

  assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_lat));

endmodule

bind vec_ffirst_seq vec_ffirst_seq_chk #(.MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cr_valid(cr_valid), .busy(busy),
  .elem_idx(elem_idx), .reg_we(reg_we), .cr_we(cr_we), .done(done),
  .vl_out(vl_out), .vl_lat(vl_q), .rc1_lat(rc1_q), .live(live)
);

// File: tb/tb_vec_ffirst_seq.sv
module tb_vec_ffirst_seq;
  localparam int MAXVL = 64;
  localparam int IW = $clog2(MAXVL);
  localparam int VW = $clog2(MAXVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VW-1:0] vl_in = '0;
  logic rc = 0, rc1 = 0, vli = 0, inv = 0;
  logic [1:0] bit_sel = '0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic cr_valid = 1'b0;
  logic [3:0] cr_in = '0;
  logic busy, reg_we, cr_we, done;
  logic [IW-1:0] elem_idx;
  logic [VW-1:0] vl_out;

  int n_chk = 0, n_bad = 0;
  logic [3:0] crs [16];

  always #2.5 clk = ~clk;

  vec_ffirst_seq #(.MAXVL(MAXVL)) dut (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(string tag, int vl, bit m_rc, bit m_rc1, bit m_vli, bit m_inv,
                     int sel, logic [MAXVL-1:0] mask, bit gap, bit poke);
    int exp_vl = vl;
    @(negedge clk);
    start = 1; vl_in = VW'(vl); rc = m_rc; rc1 = m_rc1; vli = m_vli; inv = m_inv;
    bit_sel = 2'(sel); pred_mask = mask;
    @(negedge clk);
    start = 0;
    if (vl == 0) begin
      #1;
      check({tag, " R1 done"}, done, 1);
      check({tag, " R1 vl"}, vl_out, 0);
      check({tag, " R1 busy"}, busy, 0);
      @(negedge clk);
      return;
    end
    for (int i = 0; i < vl; i++) begin
      bit tb, ps, stop, incl;
      if (gap && i == 1) begin
        cr_valid = 0; cr_in = crs[i];
        #1;
        check({tag, " R2 stall we"}, reg_we | cr_we, 0);
        @(negedge clk);
      end
      cr_valid = 1; cr_in = crs[i];
      if (poke && i == 1) begin start = 1; vl_in = VW'(1); end
      incl = m_vli && !m_rc;
      tb = m_rc ? crs[i][3 - sel] : crs[i][1];
      ps = tb ^ m_inv;
      stop = 0;
      #1;
      check({tag, " R2 idx"}, elem_idx, i);
      if (!mask[i]) begin
        check({tag, " R10 reg_we"}, reg_we, 0);
        check({tag, " R10 cr_we"}, cr_we, 0);
      end else begin
        check({tag, " R3/R5/R8/R13 reg_we"}, reg_we, (!m_rc1 && (ps || incl)) ? 1 : 0);
        check({tag, " R7/R8/R13 cr_we"}, cr_we, (m_rc || m_rc1) ? 1 : 0);
        if (!ps) begin stop = 1; exp_vl = incl ? i + 1 : i; end
      end
      @(negedge clk);
      start = 0;
      if (stop) break;
    end
    cr_valid = 1; cr_in = 4'b0000;
    #1;
    check({tag, " R11 done"}, done, 1);
    check({tag, " R11 busy"}, busy, 0);
    check({tag, " R11 no write"}, reg_we | cr_we, 0);
    check({tag, " R4/R5/R6/R9 vl"}, vl_out, exp_vl);
    @(negedge clk);
    cr_valid = 0;
    #1;
    check({tag, " R11 pulse"}, done, 0);
    check({tag, " R11 vl hold"}, vl_out, exp_vl);
  endtask

  task automatic t_reset();
    #1;
    check("R11 reset busy", busy, 0);
    check("R11 reset done", done, 0);
    check("R9 reset vl", vl_out, 0);
    check("R11 reset we", reg_we | cr_we, 0);
  endtask

  task automatic t_nofail();
    for (int i = 0; i < 16; i++) crs[i] = 4'b0010;
    run("R9 nofail", 5, 0, 0, 0, 0, 0, '1, 0, 0);
  endtask

  task automatic t_excl();
    for (int i = 0; i < 16; i++) crs[i] = 4'b0010;
    crs[3] = 4'b1000;
    run("R4 excl", 8, 0, 0, 0, 0, 0, '1, 0, 0);
  endtask

  task automatic t_incl();
    for (int i = 0; i < 16; i++) crs[i] = 4'b0000;
    crs[2] = 4'b0010;
    run("R5 incl", 7, 0, 0, 1, 1, 0, '1, 0, 0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < 16; i++) crs[i] = 4'b0010;
    crs[0] = 4'b0001;
    run("R6 zero", 6, 0, 0, 0, 0, 0, '1, 0, 0);
  endtask

  task automatic t_rc_sel();
    for (int i = 0; i < 16; i++) crs[i] = 4'b1000;
    crs[2] = 4'b0100;
    run("R7 rc gt", 6, 1, 0, 1, 1, 1, '1, 0, 0);
    for (int i = 0; i < 16; i++) crs[i] = 4'b0001;
    crs[4] = 4'b0000;
    run("R3 rc so", 9, 1, 0, 0, 0, 3, '1, 0, 0);
  endtask

  task automatic t_rc1();
    for (int i = 0; i < 16; i++) crs[i] = 4'b1000;
    crs[3] = 4'b0010;
    run("R8 rc1", 10, 0, 1, 1, 1, 0, '1, 0, 0);
    for (int i = 0; i < 16; i++) crs[i] = 4'b0010;
    run("R8 rc1 full", 4, 0, 1, 0, 0, 0, '1, 0, 0);
  endtask

  task automatic t_mask();
    for (int i = 0; i < 16; i++) crs[i] = 4'b0010;
    crs[2] = 4'b0000;
    crs[5] = 4'b0000;
    run("R10 mask", 8, 0, 0, 0, 0, 0, ~(64'b1 << 2), 0, 0);
  endtask

  task automatic t_empty();
    run("R1 empty", 0, 0, 0, 0, 0, 0, '1, 0, 0);
  endtask

  task automatic t_gap_poke();
    for (int i = 0; i < 16; i++) crs[i] = 4'b0010;
    run("R12 poke", 6, 0, 0, 0, 0, 0, '1, 1, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    t_reset();
    t_nofail();
    t_excl();
    t_incl();
    t_zero();
    t_rc_sel();
    t_rc1();
    t_mask();
    t_empty();
    t_gap_poke();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule